// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the bit-level engine that an I2C master uses after the byte engine has finished: it drives the acknowledge bit that follows a received byte, and it generates the stop condition that ends a transfer. Software requests an acknowledge with a one-cycle `ack_go` pulse and the bit to send on `ack_bit`, or requests a stop with a one-cycle `stop_go` pulse. The block then runs the sequence alone and reports back through sticky flags.

Timing comes from an internal down-counter that reloads from `brg_reload` (N). One timing period is N+1 system clocks. Both lines are open-drain: the block asserts `scl_drive_low` and `sda_drive_low` and reads the real levels on `scl_in` and `sda_in`. In every phase the block first waits until the line reads back at the level it expects. Only then does it reload the counter. A slave that stretches the clock, or holds SDA low, therefore lengthens the phase cycle for cycle. If software writes the transmit buffer while a sequence runs, the write is refused and a collision flag is raised.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset both line drivers are released (`scl_drive_low`=0, `sda_drive_low`=0), both busy outputs and all three flags are 0, and `tx_buf` is 0.
- R2: An `ack_go` pulse in idle sets `ack_busy` and `scl_drive_low` from the next cycle on. For the whole sequence, `sda_drive_low` is 1 when `ack_bit`=0 (acknowledge) and 0 when `ack_bit`=1 (not-acknowledge).
- R3: Every phase lasts N+2 cycles: one cycle for the line to read back at its driven level, then N+1 counted cycles. An acknowledge with no stretching holds SCL low for N+2 cycles and is busy for 2N+4 cycles in total.
- R4: In the acknowledge high phase, counting starts only after `scl_in` reads 1, so a stretch of S cycles gives 2N+4+S busy cycles. At the end `ack_busy` clears, `irq_flag` is set, and SCL stays driven low after the sequence.
- R5: A `stop_go` pulse in idle drives SDA and SCL low from the next cycle on. SCL is released N+2 cycles after the start, and SDA stays low until one period after SCL reads high (2N+4+S cycles with an SCL stretch of S).
- R6: A stop never sets `stop_seen` and never drives SDA low during an acknowledge sequence. An acknowledge sequence leaves `stop_seen` at 0.
- R7: `stop_seen` is set on the cycle after SDA and SCL both read 1 following the SDA release, at busy cycle 2N+5+S+D when a slave holds SDA low for D extra cycles.
- R8: One period after the stop is detected, `stop_busy` clears (3N+6+S+D busy cycles in total), `irq_flag` is set, and both lines are left released.
- R9: A `buf_wr` in idle loads `buf_wdata` into `tx_buf` and leaves `wcol_flag` at 0. A `buf_wr` while either sequence is busy sets `wcol_flag` and leaves `tx_buf` unchanged.
- R10: The flags are sticky and are cleared only by writing 1 to their `flag_clr` bit: bit 0 clears `irq_flag`, bit 1 clears `wcol_flag`, bit 2 clears `stop_seen`. A clear of one bit leaves the other flags unchanged.
- R11: When `ack_go` and `stop_go` arrive together in idle, only the acknowledge runs. A go pulse that arrives while a sequence is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brg_reload | input | CNT_W | Period reload value N (one period = N+1 clocks) |
| ack_go | input | 1 | Pulse: start an acknowledge sequence |
| ack_bit | input | 1 | Bit to send: 0 = acknowledge, 1 = not-acknowledge |
| stop_go | input | 1 | Pulse: start a stop sequence |
| buf_wr | input | 1 | Write strobe for the transmit buffer |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| flag_clr | input | 3 | Write-1-to-clear: bit 0 irq, bit 1 collision, bit 2 stop seen |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Open-drain enable that pulls SCL low |
| sda_drive_low | output | 1 | Open-drain enable that pulls SDA low |
| ack_busy | output | 1 | Acknowledge sequence in progress |
| stop_busy | output | 1 | Stop sequence in progress |
| irq_flag | output | 1 | Sticky: a sequence has completed |
| wcol_flag | output | 1 | Sticky: a buffer write was refused |
| stop_seen | output | 1 | Sticky: stop condition observed on the bus |
| tx_buf | output | DATA_W | Transmit buffer contents |

## Verification
Acknowledge sequences are run with both bit values and with reload values of 0, 3 and 5. This separates the per-phase readback cycle from the counted period, and shows whether SDA follows the requested bit. A slave that stretches SCL, and a slave that holds SDA past the release, are each applied to a stop. Comparing busy length, SCL-low and SDA-low cycle counts and the stop-detect cycle against the stretch-free runs shows that counting waits for the line level, not for the drive. Simultaneous and mid-sequence go pulses, buffer writes during both sequences and selective flag clears exercise priority, collision and stickiness.

// File: rtl/ackstop_pkg.sv
package ackstop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_LOW,
    ST_ACK_HIGH,
    ST_STP_SDA,
    ST_STP_SCL,
    ST_STP_REL
  } seq_state_t;

  localparam int FLAG_N   = 3;
  localparam int FLAG_IRQ = 0;
  localparam int FLAG_COL = 1;
  localparam int FLAG_STP = 2;

  // Line level a phase must read back before its period may start.
  function automatic logic line_level_ok(seq_state_t st, logic scl, logic sda);
    case (st)
      ST_ACK_LOW:  return !scl;
      ST_ACK_HIGH: return scl;
      ST_STP_SDA:  return !sda;
      ST_STP_SCL:  return scl;
      ST_STP_REL:  return scl && sda;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ackstop_brg.sv
module ackstop_brg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  input  logic             arm,
  input  logic             halt,
  output logic             tick,
  output logic             armed
);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  function automatic logic [CNT_W-1:0] count_down(logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (halt) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm) begin
      cnt_q   <= reload;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      cnt_q   <= count_down(cnt_q);
    end
  end

  assign tick  = armed_q && (cnt_q == '0);
  assign armed = armed_q;

  // R3: a running period is never restarted by the sequencer
  p_no_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !armed_q);

endmodule

// File: rtl/ackstop_fsm.sv
module ackstop_fsm
  import ackstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_go,
  input  logic       ack_bit,
  input  logic       stop_go,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       tick,
  input  logic       armed,
  output logic       arm,
  output logic       halt,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic       ack_busy,
  output logic       stop_busy,
  output logic       stop_det,
  output logic       seq_done
);

  seq_state_t state_q, state_d;
  logic       ack_bit_q;
  logic       scl_hold_q;
  logic       level_ok;

  assign level_ok = line_level_ok(state_q, scl_in, sda_in);
  assign arm      = (state_q != ST_IDLE) && level_ok && !armed;
  assign halt     = tick;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ack_go)       state_d = ST_ACK_LOW;
        else if (stop_go) state_d = ST_STP_SDA;
      end
      ST_ACK_LOW:  if (tick) state_d = ST_ACK_HIGH;
      ST_ACK_HIGH: if (tick) state_d = ST_IDLE;
      ST_STP_SDA:  if (tick) state_d = ST_STP_SCL;
      ST_STP_SCL:  if (tick) state_d = ST_STP_REL;
      ST_STP_REL:  if (tick) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ack_bit_q  <= 1'b1;
      scl_hold_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && ack_go)
        ack_bit_q <= ack_bit;
      if (tick && state_q == ST_ACK_HIGH)
        scl_hold_q <= 1'b1;
      else if (tick && state_q == ST_STP_SDA)
        scl_hold_q <= 1'b0;
    end
  end

  assign ack_busy  = (state_q == ST_ACK_LOW) || (state_q == ST_ACK_HIGH);
  assign stop_busy = (state_q == ST_STP_SDA) || (state_q == ST_STP_SCL) ||
                     (state_q == ST_STP_REL);

  assign scl_drive_low = (state_q == ST_ACK_LOW) || (state_q == ST_STP_SDA) ||
                         ((state_q == ST_IDLE) && scl_hold_q);
  assign sda_drive_low = (ack_busy && !ack_bit_q) ||
                         (state_q == ST_STP_SDA) || (state_q == ST_STP_SCL);

  assign stop_det = (state_q == ST_STP_REL) && arm;
  assign seq_done = tick && ((state_q == ST_ACK_HIGH) || (state_q == ST_STP_REL));

  // R2: acknowledge start pulls SCL low on the next cycle
  p_ack_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && ack_go) |=> (ack_busy && scl_drive_low));

  // R4: high phase cannot end while a slave still holds SCL low
  p_stretch_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK_HIGH && !scl_in && !armed) |=> (state_q == ST_ACK_HIGH));

  // R5: while SCL is released for the stop, SDA is still held low
  p_stop_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STP_SCL) |-> (sda_drive_low && !scl_drive_low));

  // R11: never both sequences at once
  p_one_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_busy, stop_busy}));

endmodule

// File: rtl/ackstop_flags.sv
module ackstop_flags
  import ackstop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_irq,
  input  logic              set_stop,
  input  logic              busy,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic              irq_flag,
  output logic              wcol_flag,
  output logic              stop_seen,
  output logic [DATA_W-1:0] tx_buf
);

  logic [FLAG_N-1:0] flag_q;
  logic [FLAG_N-1:0] flag_set;
  logic [DATA_W-1:0] buf_q;

  assign flag_set[FLAG_IRQ] = set_irq;
  assign flag_set[FLAG_COL] = buf_wr && busy;
  assign flag_set[FLAG_STP] = set_stop;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)            flag_q[i] <= 1'b0;
      else if (flag_set[i])  flag_q[i] <= 1'b1;
      else if (flag_clr[i])  flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                buf_q <= '0;
    else if (buf_wr && !busy)  buf_q <= buf_wdata;
  end

  assign irq_flag  = flag_q[FLAG_IRQ];
  assign wcol_flag = flag_q[FLAG_COL];
  assign stop_seen = flag_q[FLAG_STP];
  assign tx_buf    = buf_q;

  // R9: a refused write flags a collision and keeps the buffer
  p_wcol_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> (wcol_flag && $stable(tx_buf)));

  // R10: the interrupt flag only drops after a software clear
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr[FLAG_IRQ]) |=> irq_flag);

endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
  import ackstop_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  brg_reload,
  input  logic              ack_go,
  input  logic              ack_bit,
  input  logic              stop_go,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic [2:0]        flag_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              ack_busy,
  output logic              stop_busy,
  output logic              irq_flag,
  output logic              wcol_flag,
  output logic              stop_seen,
  output logic [DATA_W-1:0] tx_buf
);

  localparam int CLR_W = FLAG_N;

  logic brg_tick, brg_armed, brg_arm, brg_halt;
  logic stop_det, seq_done, any_busy;

  ackstop_brg #(.CNT_W(CNT_W)) u_brg (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (brg_reload),
    .arm    (brg_arm),
    .halt   (brg_halt),
    .tick   (brg_tick),
    .armed  (brg_armed)
  );

  ackstop_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_go        (ack_go),
    .ack_bit       (ack_bit),
    .stop_go       (stop_go),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .tick          (brg_tick),
    .armed         (brg_armed),
    .arm           (brg_arm),
    .halt          (brg_halt),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .ack_busy      (ack_busy),
    .stop_busy     (stop_busy),
    .stop_det      (stop_det),
    .seq_done      (seq_done)
  );

  assign any_busy = ack_busy || stop_busy;

  ackstop_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_irq   (seq_done),
    .set_stop  (stop_det),
    .busy      (any_busy),
    .buf_wr    (buf_wr),
    .buf_wdata (buf_wdata),
    .flag_clr  (flag_clr[CLR_W-1:0]),
    .irq_flag  (irq_flag),
    .wcol_flag (wcol_flag),
    .stop_seen (stop_seen),
    .tx_buf    (tx_buf)
  );

  // R7: stop is only recognised after both lines read high
  p_stop_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> $past(scl_in && sda_in));

  // R8: completion of any sequence raises the interrupt flag
  p_irq_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_busy) |-> irq_flag);

  // R6: acknowledge never raises the stop flag by itself
  p_ack_no_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_busy && !stop_seen) |=> !stop_seen);

endmodule

// File: tb/i2c_ackstop_seq_bench.sv
`timescale 1ns/1ps
module i2c_ackstop_seq_bench;

  localparam int CW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] brg_reload;
  logic          ack_go, ack_bit, stop_go, buf_wr;
  logic [DW-1:0] buf_wdata;
  logic [2:0]    flag_clr;
  logic          scl_in, sda_in;
  logic          scl_drive_low, sda_drive_low, ack_busy, stop_busy;
  logic          irq_flag, wcol_flag, stop_seen;
  logic [DW-1:0] tx_buf;

  always #2 clk = ~clk;

  i2c_ackstop_seq #(.CNT_W(CW), .DATA_W(DW)) u_i2c_ackstop_seq (
    .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .ack_go(ack_go),
    .ack_bit(ack_bit), .stop_go(stop_go), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .flag_clr(flag_clr), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .ack_busy(ack_busy), .stop_busy(stop_busy), .irq_flag(irq_flag),
    .wcol_flag(wcol_flag), .stop_seen(stop_seen), .tx_buf(tx_buf)
  );

  // Bus model: a slave keeps each line low for a set number of cycles after release.
  int scl_stretch = 0, sda_stretch = 0;
  int scl_cnt = 0, sda_cnt = 0;
  always @(posedge clk) begin
    if (scl_drive_low) scl_cnt <= scl_stretch; else if (scl_cnt > 0) scl_cnt <= scl_cnt - 1;
    if (sda_drive_low) sda_cnt <= sda_stretch; else if (sda_cnt > 0) sda_cnt <= sda_cnt - 1;
  end
  assign scl_in = !scl_drive_low && (scl_cnt == 0);
  assign sda_in = !sda_drive_low && (sda_cnt == 0);

  typedef struct {
    string rq;
    int    busy;
    int    scl_lo;
    int    sda_lo;
    int    ss_at;
  } exp_t;

  exp_t q[$];
  int   checks = 0, fails = 0;

  task automatic check_int(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Each phase: one readback cycle plus a period of n+1 clocks.
  function automatic int phase(int n); return (n + 1) + 1; endfunction
  function automatic exp_t ack_exp(int n, bit b, int s);
    exp_t e;
    e.rq = "R3/R4"; e.busy = 2 * phase(n) + s; e.scl_lo = phase(n);
    e.sda_lo = b ? 0 : e.busy; e.ss_at = -1;
    return e;
  endfunction
  function automatic exp_t stop_exp(int n, int s, int d);
    exp_t e;
    e.rq = "R5/R7/R8"; e.scl_lo = phase(n); e.sda_lo = 2 * phase(n) + s;
    e.ss_at = e.sda_lo + d + 1; e.busy = 3 * phase(n) + s + d;
    return e;
  endfunction

  // Monitor: measures each busy window and compares with the queue head.
  int m_cnt, m_sl, m_dl, m_ss;
  bit m_was = 1'b0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (ack_busy || stop_busy) begin
        if (!m_was) begin m_cnt = 0; m_sl = 0; m_dl = 0; m_ss = -1; end
        if (stop_seen && m_ss < 0) m_ss = m_cnt;
        if (scl_drive_low) m_sl++;
        if (sda_drive_low) m_dl++;
        m_cnt++;
        m_was = 1'b1;
      end else if (m_was) begin
        exp_t e;
        m_was = 1'b0;
        if (q.size() == 0) check_int("R11", "unexpected sequence", 1, 0);
        else begin
          e = q.pop_front();
          check_int(e.rq, "busy cycles", m_cnt, e.busy);
          check_int(e.rq, "SCL low cycles", m_sl, e.scl_lo);
          check_int(e.rq, "SDA low cycles", m_dl, e.sda_lo);
          check_int(e.rq, "stop detect cycle", m_ss, e.ss_at);
        end
      end
    end
  end

  task automatic clear_flags(logic [2:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  task automatic wait_idle();
    int g = 0;
    @(negedge clk);
    while ((ack_busy || stop_busy) && g < 5000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_ack(int n, bit b, int s, bit stop_mid, bit wr_mid);
    brg_reload = CW'(n); scl_stretch = s; sda_stretch = 0;
    clear_flags(3'b111);
    q.push_back(ack_exp(n, b, s));
    @(negedge clk) begin ack_bit = b; ack_go = 1'b1; end
    @(negedge clk) ack_go = 1'b0;
    @(negedge clk) begin stop_go = stop_mid; buf_wr = wr_mid; buf_wdata = 8'hA5; end
    @(negedge clk) begin stop_go = 1'b0; buf_wr = 1'b0; end
    wait_idle();
    check_int("R4", "irq after ack", int'(irq_flag), 1);
    check_int("R4", "SCL held after ack", int'(scl_drive_low), 1);
    check_int("R6", "stop_seen after ack", int'(stop_seen), 0);
    if (wr_mid) begin
      check_int("R9", "wcol during ack", int'(wcol_flag), 1);
      check_int("R9", "tx_buf kept", int'(tx_buf), 8'h3C);
    end
  endtask

  task automatic run_stop(int n, int s, int d, bit wr_mid);
    brg_reload = CW'(n); scl_stretch = s; sda_stretch = d;
    clear_flags(3'b111);
    q.push_back(stop_exp(n, s, d));
    @(negedge clk) stop_go = 1'b1;
    @(negedge clk) begin
      stop_go = 1'b0;
      check_int("R5", "SDA low at stop start", int'(sda_drive_low), 1);
    end
    @(negedge clk) begin buf_wr = wr_mid; buf_wdata = 8'h5A; end
    @(negedge clk) buf_wr = 1'b0;
    wait_idle();
    check_int("R7", "stop_seen", int'(stop_seen), 1);
    check_int("R8", "irq after stop", int'(irq_flag), 1);
    check_int("R8", "SCL released", int'(scl_drive_low), 0);
    check_int("R8", "SDA released", int'(sda_drive_low), 0);
    if (wr_mid) begin
      check_int("R9", "wcol during stop", int'(wcol_flag), 1);
      check_int("R9", "tx_buf kept", int'(tx_buf), 8'h3C);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; brg_reload = '0; ack_go = 0; ack_bit = 0; stop_go = 0;
    buf_wr = 0; buf_wdata = '0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_int("R1", "scl_drive_low", int'(scl_drive_low), 0);
    check_int("R1", "sda_drive_low", int'(sda_drive_low), 0);
    check_int("R1", "busy", int'(ack_busy || stop_busy), 0);
    check_int("R1", "flags", int'({irq_flag, wcol_flag, stop_seen}), 0);
    check_int("R1", "tx_buf", int'(tx_buf), 0);

    // R9 idle write is accepted
    @(negedge clk) begin buf_wr = 1'b1; buf_wdata = 8'h3C; end
    @(negedge clk) buf_wr = 1'b0;
    @(negedge clk);
    check_int("R9", "idle write", int'(tx_buf), 8'h3C);
    check_int("R9", "no wcol in idle", int'(wcol_flag), 0);

    // R2/R3/R4 acknowledge variants
    run_ack(3, 1'b0, 0, 1'b0, 1'b0);
    run_ack(0, 1'b1, 0, 1'b0, 1'b0);
    run_ack(5, 1'b0, 4, 1'b0, 1'b0);

    // R5/R7/R8 stop variants, R9 collision during stop
    run_stop(3, 0, 0, 1'b0);
    run_stop(0, 0, 0, 1'b0);
    run_stop(4, 3, 2, 1'b1);

    // R10 selective clear
    clear_flags(3'b010);
    @(negedge clk);
    check_int("R10", "wcol cleared", int'(wcol_flag), 0);
    check_int("R10", "irq kept", int'(irq_flag), 1);
    check_int("R10", "stop_seen kept", int'(stop_seen), 1);
    clear_flags(3'b001);
    @(negedge clk);
    check_int("R10", "irq cleared", int'(irq_flag), 0);
    check_int("R10", "stop_seen still kept", int'(stop_seen), 1);

    // R9 collision during ack; R11 stop pulse while busy ignored
    run_ack(6, 1'b0, 0, 1'b1, 1'b1);

    // R11 both go pulses together: only the acknowledge runs
    brg_reload = CW'(2); scl_stretch = 0; sda_stretch = 0;
    clear_flags(3'b111);
    q.push_back(ack_exp(2, 1'b1, 0));
    @(negedge clk) begin ack_bit = 1'b1; ack_go = 1'b1; stop_go = 1'b1; end
    @(negedge clk) begin ack_go = 1'b0; stop_go = 1'b0; end
    check_int("R11", "stop_busy with both go", int'(stop_busy), 0);
    wait_idle();
    repeat (4) @(negedge clk);
    check_int("R11", "no stop after priority", int'(stop_seen), 0);
    check_int("R11", "SCL still held", int'(scl_drive_low), 1);
    check_int("R11", "pending items", q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule